// File: doc/BRIEF.md
# RMII Receive Adapter

This block sits between the receive side of a 10/100 Ethernet transceiver and a MAC that uses the reduced pin-count media independent interface. Recovered bytes arrive with a one-cycle strobe, together with a carrier indication. The block turns them into a two-bit receive data bus and a combined carrier/data-valid line, both registered on the 50 MHz reference clock. At 100 Mb/s each byte takes four consecutive clocks. At 10 Mb/s each two-bit group is held for ten clocks.

The data bus stays at zero from the start of carrier until the start-frame delimiter byte arrives. From that byte on, data passes unchanged. After carrier ends, any buffered data still drains. During that drain the carrier/data-valid line alternates at two-bit-group boundaries, which tells the MAC that carrier has gone while data is still valid. When the buffer is empty the line drops.

In 10 Mb/s half-duplex, a carrier event that starts while the local transmitter is active is the echo of that transmission. Such an event is not shown to the MAC. A small byte buffer absorbs the phase difference between the byte strobe and the output slots.

Top module: `rmii_rx_adapter`

## Requirements
- R1: Each byte is sent as four two-bit groups, bits [1:0] first and bits [7:6] last. The delimiter byte 0xD5 (wire order 10101011) therefore appears as 01, 01, 01, 11.
- R2: `rmii_crs_dv` is 1 from the clock after `rx_carrier` rises and stays 1 for as long as carrier lasts. `rmii_rxd` is 00 while carrier is up and no byte is buffered.
- R3: Within one carrier event, every byte accepted before the first 0xD5 byte is output as 00 groups. The 0xD5 byte and every later byte pass unchanged, including later 0xD5 bytes. A carrier event without a 0xD5 byte never drives `rmii_rxd` away from 00.
- R4: At 100 Mb/s (`spd_100`=1) one group is output per clock with no gap between bytes. The first group of a byte appears two clocks after the clock on which its strobe was sampled, provided the output is idle or finishing its previous byte then.
- R5: At 10 Mb/s (`spd_100`=0) each group, together with its `rmii_crs_dv` value, is held for exactly 10 clocks.
- R6: A group that starts after carrier has fallen carries `rmii_crs_dv` = 0 at even positions within its byte (0 and 2) and 1 at odd positions (1 and 3). `rmii_crs_dv` changes only at group boundaries.
- R7: On the clock after the last buffered group ends with carrier down, `rmii_crs_dv` is 0 and `rmii_rxd` is 00.
- R8: A carrier event that begins with `spd_100`=0, `duplex_full`=0 and `tx_busy`=1 keeps `rmii_crs_dv` at 0 and `rmii_rxd` at 00 for its whole length. With `spd_100`=1 or `duplex_full`=1 the event is received normally.
- R9: Byte strobes while `rx_carrier` is 0 are ignored.
- R10: A buffer of FIFO_DEPTH bytes (16 groups by default) lies between the byte input and the output. When bytes arrive no faster than the output rate, no byte is lost or reordered.
- R11: After reset, `rmii_crs_dv` is 0 and `rmii_rxd` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst | input | 1 | Synchronous active-high reset |
| spd_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| duplex_full | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_busy | input | 1 | Local transmitter is active |
| rx_carrier | input | 1 | Receive medium is non-idle |
| rx_byte_vld | input | 1 | One-cycle strobe for a recovered byte |
| rx_byte | input | 8 | Recovered byte, bit 0 first on the wire |
| rmii_crs_dv | output | 1 | Carrier sense / data valid |
| rmii_rxd | output | 2 | Receive data group |

## Verification
The assertions rely on four assumptions about the inputs:
- Byte strobes come no faster than one per 4 clocks at 100 Mb/s and one per 40 clocks at 10 Mb/s, so the buffer cannot fill.
- Speed and duplex stay fixed while a frame is being received or drained.
- A new carrier event starts only after the previous one has fully drained.
- The checks on how an event starts apply only when the output is idle at that moment.

The stimulus respects all four. It spaces strobes at exactly the output rate. It changes speed and duplex only between frames. It leaves a tail longer than one byte time after each event. The one deliberate exception is a stray strobe with carrier low, which is issued on purpose to exercise the ignore rule.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;
  localparam int BYTE_W    = 8;
  localparam int GRP_W     = 2;
  localparam int GRPS_PER_B = BYTE_W / GRP_W;

  typedef logic [GRP_W-1:0]  grp_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // Group index of the final group inside one byte.
  localparam logic [1:0] LAST_GRP = 2'(GRPS_PER_B - 1);
endpackage

// File: rtl/rmii_rx_frame_ctl.sv
module rmii_rx_frame_ctl
  import rmii_rx_pkg::*;
#(
  parameter byte_t SFD_CODE = 8'hD5
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  spd_100,
  input  logic  duplex_full,
  input  logic  tx_busy,
  input  logic  rx_carrier,
  input  logic  rx_byte_vld,
  input  byte_t rx_byte,
  output logic  wr_en,
  output byte_t wr_byte,
  output logic  carrier_live
);
  logic carrier_q;
  logic echo_q;
  logic sfd_seen_q;
  logic echo_cond;
  logic echo_now;
  logic sfd_hit;

  // Echo of own transmission: only in 10 Mb half duplex.
  assign echo_cond    = !spd_100 && !duplex_full && tx_busy;
  // Decision taken on the first carrier cycle, then held for the event.
  assign echo_now     = carrier_q ? echo_q : echo_cond;
  assign carrier_live = rx_carrier && !echo_now;

  assign sfd_hit = (rx_byte == SFD_CODE);
  assign wr_en   = rx_carrier && rx_byte_vld && !echo_now;
  assign wr_byte = (sfd_seen_q || sfd_hit) ? rx_byte : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      carrier_q  <= 1'b0;
      echo_q     <= 1'b0;
      sfd_seen_q <= 1'b0;
    end else begin
      carrier_q <= rx_carrier;
      if (rx_carrier && !carrier_q) begin
        echo_q <= echo_cond;
      end
      if (!rx_carrier) begin
        sfd_seen_q <= 1'b0;
      end else if (wr_en && sfd_hit) begin
        sfd_seen_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_fifo.sv
module rmii_rx_fifo
  import rmii_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  byte_t push_data,
  input  logic  pop,
  output byte_t pop_data,
  output logic  empty,
  output logic  full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  byte_t           mem [DEPTH];
  logic [AW-1:0]   wr_ptr;
  logic [AW-1:0]   rd_ptr;
  logic [CW-1:0]   count;
  logic            do_push;
  logic            do_pop;

  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem[rd_ptr];

  // Storage without reset so the tool may map it to distributed RAM.
  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) begin
        wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) begin
        rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rmii_rx_serializer.sv
module rmii_rx_serializer
  import rmii_rx_pkg::*;
#(
  parameter int SLOW_DIV = 10
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  spd_100,
  input  logic  carrier_live,
  input  logic  fifo_empty,
  input  byte_t fifo_data,
  output logic  fifo_pop,
  output logic  crs_dv,
  output grp_t  rxd,
  output logic  busy_o,
  output logic  mid_slot_o
);
  localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic                    busy;
  logic [1:0]              idx;
  logic [PW-1:0]           pace;
  logic [BYTE_W-GRP_W-1:0] shreg;
  logic                    slot_end;
  logic                    need_load;
  logic [1:0]              idx_nx;

  generate
    if (SLOW_DIV > 1) begin : g_div
      assign slot_end = busy && (spd_100 || (pace == PW'(SLOW_DIV - 1)));
    end else begin : g_nodiv
      assign slot_end = busy;
    end
  endgenerate

  assign need_load  = (!busy || (slot_end && idx == LAST_GRP)) && !fifo_empty;
  assign fifo_pop   = need_load;
  assign idx_nx     = idx + 1'b1;
  assign busy_o     = busy;
  assign mid_slot_o = (pace != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      idx    <= '0;
      pace   <= '0;
      shreg  <= '0;
      rxd    <= '0;
      crs_dv <= 1'b0;
    end else if (need_load) begin
      busy   <= 1'b1;
      idx    <= '0;
      pace   <= '0;
      shreg  <= fifo_data[BYTE_W-1:GRP_W];
      rxd    <= fifo_data[GRP_W-1:0];
      crs_dv <= carrier_live;
    end else if (slot_end && idx != LAST_GRP) begin
      idx    <= idx_nx;
      pace   <= '0;
      shreg  <= {{GRP_W{1'b0}}, shreg[BYTE_W-GRP_W-1:GRP_W]};
      rxd    <= shreg[GRP_W-1:0];
      crs_dv <= carrier_live || idx_nx[0];
    end else if (slot_end) begin
      busy   <= 1'b0;
      pace   <= '0;
      rxd    <= '0;
      crs_dv <= carrier_live;
    end else if (!busy) begin
      pace   <= '0;
      rxd    <= '0;
      crs_dv <= carrier_live;
    end else begin
      pace <= pace + 1'b1;
    end
  end
endmodule

// File: rtl/rmii_rx_adapter.sv
module rmii_rx_adapter
  import rmii_rx_pkg::*;
#(
  parameter int    FIFO_DEPTH = 4,
  parameter int    SLOW_DIV   = 10,
  parameter byte_t SFD_CODE   = 8'hD5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       spd_100,
  input  logic       duplex_full,
  input  logic       tx_busy,
  input  logic       rx_carrier,
  input  logic       rx_byte_vld,
  input  logic [7:0] rx_byte,
  output logic       rmii_crs_dv,
  output logic [1:0] rmii_rxd
);
  logic  wr_en;
  byte_t wr_byte;
  logic  carrier_live;
  logic  fifo_pop;
  byte_t fifo_data;
  logic  fifo_empty;
  logic  fifo_full;
  logic  ser_busy;
  logic  ser_mid_slot;

  rmii_rx_frame_ctl #(.SFD_CODE(SFD_CODE)) u_ctl (
    .clk          (clk),
    .rst          (rst),
    .spd_100      (spd_100),
    .duplex_full  (duplex_full),
    .tx_busy      (tx_busy),
    .rx_carrier   (rx_carrier),
    .rx_byte_vld  (rx_byte_vld),
    .rx_byte      (rx_byte),
    .wr_en        (wr_en),
    .wr_byte      (wr_byte),
    .carrier_live (carrier_live)
  );

  rmii_rx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_en),
    .push_data (wr_byte),
    .pop       (fifo_pop),
    .pop_data  (fifo_data),
    .empty     (fifo_empty),
    .full      (fifo_full)
  );

  rmii_rx_serializer #(.SLOW_DIV(SLOW_DIV)) u_ser (
    .clk          (clk),
    .rst          (rst),
    .spd_100      (spd_100),
    .carrier_live (carrier_live),
    .fifo_empty   (fifo_empty),
    .fifo_data    (fifo_data),
    .fifo_pop     (fifo_pop),
    .crs_dv       (rmii_crs_dv),
    .rxd          (rmii_rxd),
    .busy_o       (ser_busy),
    .mid_slot_o   (ser_mid_slot)
  );
endmodule

// File: rtl/rmii_rx_adapter_chk.sv
module rmii_rx_adapter_chk (
  input logic       clk,
  input logic       rst,
  input logic       spd_100,
  input logic       duplex_full,
  input logic       tx_busy,
  input logic       rx_carrier,
  input logic       rmii_crs_dv,
  input logic [1:0] rmii_rxd,
  input logic       wr_en,
  input logic       fifo_empty,
  input logic       fifo_full,
  input logic       ser_busy,
  input logic       ser_mid_slot
);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !fifo_full);

  // R8
  echo_hidden_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_carrier) && !spd_100 && !duplex_full && tx_busy && fifo_empty && !ser_busy)
      |=> !rmii_crs_dv);

  // R2
  carrier_rise_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_carrier) && (spd_100 || duplex_full || !tx_busy) && fifo_empty && !ser_busy)
      |=> rmii_crs_dv);

  // R5
  slow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!spd_100 && ser_busy && ser_mid_slot) |-> ($stable(rmii_rxd) && $stable(rmii_crs_dv)));

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_empty && !ser_busy) |=> (rmii_rxd == 2'b00));
endmodule

bind rmii_rx_adapter rmii_rx_adapter_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .spd_100      (spd_100),
  .duplex_full  (duplex_full),
  .tx_busy      (tx_busy),
  .rx_carrier   (rx_carrier),
  .rmii_crs_dv  (rmii_crs_dv),
  .rmii_rxd     (rmii_rxd),
  .wr_en        (wr_en),
  .fifo_empty   (fifo_empty),
  .fifo_full    (fifo_full),
  .ser_busy     (ser_busy),
  .ser_mid_slot (ser_mid_slot)
);

// File: tb/tb_rmii_rx_adapter.sv
module tb_rmii_rx_adapter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       spd_100 = 1'b0;
  logic       duplex_full = 1'b0;
  logic       tx_busy = 1'b0;
  logic       rx_carrier = 1'b0;
  logic       rx_byte_vld = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rmii_crs_dv;
  logic [1:0] rmii_rxd;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [2:0] lg [0:1023];

  always #10 clk = ~clk;

  rmii_rx_adapter dut (
    .clk         (clk),
    .rst         (rst),
    .spd_100     (spd_100),
    .duplex_full (duplex_full),
    .tx_busy     (tx_busy),
    .rx_carrier  (rx_carrier),
    .rx_byte_vld (rx_byte_vld),
    .rx_byte     (rx_byte),
    .rmii_crs_dv (rmii_crs_dv),
    .rmii_rxd    (rmii_rxd)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One carrier event, logged cycle by cycle, then compared with the rules.
  task automatic run_frame(input int f, input bit r100, input bit fdx, input bit txa,
                           input bit has_sfd, input bit stray);
    int p, bp, npre, npay, nb, t_on, t_last, tt, s0, nsl, t_end;
    bit drop;
    logic [7:0] bytes [0:15];
    p = r100 ? 1 : 10;
    bp = 4 * p;
    npre = 3;
    npay = 4;
    nb = has_sfd ? (npre + 1 + npay) : (npre + 2);
    t_on = 4;
    t_last = t_on - 1 + nb * bp;
    tt = t_last + bp + 12;
    drop = !r100 && !fdx && txa;
    for (int b = 0; b < 16; b++) begin
      if (b < npre || !has_sfd) bytes[b] = 8'h55;
      else if (b == npre) bytes[b] = 8'hD5;
      else if (b == npre + 1 && f[0]) bytes[b] = 8'hD5;
      else bytes[b] = 8'(f * 29 + b * 53 + 7);
    end
    @(negedge clk);
    spd_100 = r100;
    duplex_full = fdx;
    tx_busy = txa;
    for (int t = 0; t < tt; t++) begin
      @(negedge clk);
      lg[t] = {rmii_crs_dv, rmii_rxd};
      rx_carrier = (t >= t_on) && (t <= t_last);
      rx_byte_vld = 1'b0;
      rx_byte = 8'h00;
      if (stray && t == 1) begin
        rx_byte_vld = 1'b1;
        rx_byte = 8'hFF;
      end
      for (int b = 0; b < nb; b++) begin
        if (t == t_on - 1 + (b + 1) * bp) begin
          rx_byte_vld = 1'b1;
          rx_byte = bytes[b];
        end
      end
    end
    tx_busy = 1'b0;

    if (drop) begin
      for (int t = 0; t < tt; t++)
        chk(lg[t] == 3'b000, $sformatf("R8 frame%0d t=%0d", f, t), lg[t], 0);
      return;
    end

    for (int t = 0; t <= t_on; t++)
      chk(lg[t] == 3'b000, $sformatf("%s frame%0d t=%0d", stray ? "R9" : "R2", f, t), lg[t], 0);
    chk(lg[t_on + 1][2] == 1'b1, $sformatf("R2 rise frame%0d", f), lg[t_on + 1][2], 1);

    if (!has_sfd) begin
      for (int t = 0; t < tt; t++)
        chk(lg[t][1:0] == 2'b00, $sformatf("R3 no-delimiter frame%0d t=%0d", f, t), lg[t][1:0], 0);
      chk(lg[tt - 1] == 3'b000, $sformatf("R7 frame%0d end", f), lg[tt - 1], 0);
      return;
    end

    s0 = t_on - 1 + (npre + 1) * bp + 2;
    nsl = 4 * (1 + npay);
    for (int t = t_on + 1; t < s0; t++) begin
      chk(lg[t][1:0] == 2'b00, $sformatf("R3 hold frame%0d t=%0d", f, t), lg[t][1:0], 0);
      chk(lg[t][2] == 1'b1, $sformatf("R2 frame%0d t=%0d", f, t), lg[t][2], 1);
    end
    for (int s = 0; s < nsl; s++) begin
      logic [7:0] by;
      logic [1:0] eg;
      logic       ec;
      int         ts;
      by = bytes[npre + s / 4];
      eg = 2'(by >> (2 * (s % 4)));
      ts = s0 + s * p;
      ec = (ts - 1 <= t_last) ? 1'b1 : 1'(s % 2);
      for (int c = 0; c < p; c++) begin
        chk(lg[ts + c][1:0] == eg,
            $sformatf("%s frame%0d slot%0d c%0d", r100 ? "R1 R3 R4 R10" : "R1 R3 R5 R10", f, s, c),
            lg[ts + c][1:0], eg);
        chk(lg[ts + c][2] == ec,
            $sformatf("%s frame%0d slot%0d c%0d", (ts - 1 <= t_last) ? "R2" : "R6", f, s, c),
            lg[ts + c][2], ec);
      end
    end
    t_end = s0 + nsl * p;
    for (int t = t_end; t < tt; t++)
      chk(lg[t] == 3'b000, $sformatf("R7 frame%0d t=%0d", f, t), lg[t], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({rmii_crs_dv, rmii_rxd} == 3'b000, "R11 reset", {rmii_crs_dv, rmii_rxd}, 0);
    end
    // Sweep speed x duplex x transmitter state; odd frames repeat 0xD5 in payload.
    for (int f = 0; f < 8; f++)
      run_frame(f, f[0], f[1], f[2], 1'b1, 1'b0);
    // No delimiter at both speeds.
    run_frame(8, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    run_frame(9, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    // Stray strobes with carrier low at both speeds.
    run_frame(10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    run_frame(11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule